// File: doc/BRIEF.md
# Masked Interrupt Request Aggregator

This block gathers eight interrupt request lines into one level-sensitive interrupt for an upstream controller. Peripherals raise requests with a set strobe that carries a bit vector, and withdraw them with a clear strobe that carries a second vector. Software programs an enable mask over a byte-wide write port. The output goes high when a set, or a write to the primary mask, finds at least one pending bit whose enable bit is 1 while the block is idle. It goes low only when a clear leaves no enabled bit pending. A write to the mask never lowers the output, even if it hides every pending request. That way the upstream controller sees exactly one assertion for each episode.

The same write port also holds a mask for a second, cascaded controller. That value is stored and driven out on its own pin for the cascade. It never takes part in the interrupt decision. All strobes and writes are plain single-cycle qualifiers with no back-pressure: the block accepts every strobe in the cycle in which it is presented. Priority, vectoring and end-of-interrupt handling stay with the upstream controller.

Top module: `irq_agg`

## Requirements
- R1: After reset the pending register is zero, `irq_o` is low, and both the primary mask and `cascade_mask_o` are all ones, so any single set request asserts `irq_o`.
- R2: A set strobe ORs `set_vec_i` into the pending register. Earlier requests stay pending.
- R3: A clear strobe ANDs the pending register with the inverse of `clr_vec_i`. Bits not named in the vector stay pending.
- R4: A set asserts `irq_o` when the output is low and (pending AND primary mask) is nonzero after the update. A set that leaves that product zero does not assert it.
- R5: A clear deasserts `irq_o` when (pending AND primary mask) is zero after the update. Only a clear strobe can deassert the output.
- R6: A write to address 1 loads the primary mask from `wr_data_i`. It asserts `irq_o` if the output was low and the new mask exposes a pending bit.
- R7: A primary mask write never deasserts `irq_o`, even when the new mask is zero.
- R8: A write to address 2 loads `cascade_mask_o` from `wr_data_i` and has no effect on `irq_o`.
- R9: When a set and a clear arrive in the same cycle, the clear is applied after the set. The decision uses the resulting pending value, and the set still counts as a trigger for asserting.
- R10: `irq_o` is registered. It changes at the clock edge that samples the strobe or write that causes the change.
- R11: Writes to addresses 0 and 3 change neither mask nor `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_valid_i | input | 1 | Set strobe qualifier |
| set_vec_i | input | 8 | Request bits to make pending |
| clr_valid_i | input | 1 | Clear strobe qualifier |
| clr_vec_i | input | 8 | Request bits to withdraw |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 1 primary mask, 2 cascade mask |
| wr_data_i | input | 8 | Write data |
| irq_o | output | 1 | Level interrupt to upstream controller |
| cascade_mask_o | output | 8 | Stored mask for the cascaded controller |

## Verification
The bench sweeps every primary mask value against single-bit and multi-bit requests. This catches a design that inverts the mask sense or tests only one bit. It aims at the sticky output: a mask write of zero while the output is high, where a design that re-evaluates on mask writes would drop the line early. It also drives combined set-and-clear cycles, where applying the clear first would leave a stale request pending, or would miss an assertion. Cascade-mask writes and writes to unused addresses are mixed in so that any leak into the decision path shows up as a spurious edge on the output.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned LINES_DEF  = 8;
  localparam int unsigned ADDR_W_DEF = 2;

  typedef enum logic [ADDR_W_DEF-1:0] {
    SEL_NONE0   = 2'd0,
    SEL_PRIMARY = 2'd1,
    SEL_CASCADE = 2'd2,
    SEL_NONE3   = 2'd3
  } reg_sel_e;

  // Next pending value: set applied first, then clear.
  function automatic logic [LINES_DEF-1:0] merge_pending(
    input logic [LINES_DEF-1:0] cur,
    input logic                 set_v,
    input logic [LINES_DEF-1:0] set_bits,
    input logic                 clr_v,
    input logic [LINES_DEF-1:0] clr_bits);
    logic [LINES_DEF-1:0] t;
    t = set_v ? (cur | set_bits) : cur;
    return clr_v ? (t & ~clr_bits) : t;
  endfunction
endpackage

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
  parameter int unsigned LINES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_valid_i,
  input  logic [LINES-1:0] set_vec_i,
  input  logic             clr_valid_i,
  input  logic [LINES-1:0] clr_vec_i,
  output logic [LINES-1:0] pend_next_o,
  output logic [LINES-1:0] pend_q_o
);
  logic [LINES-1:0] pend_q;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic raise_s;
    logic drop_s;
    assign raise_s = set_valid_i & set_vec_i[g];
    assign drop_s  = clr_valid_i & clr_vec_i[g];
    // clear wins over set within one cycle
    assign pend_next_o[g] = (pend_q[g] | raise_s) & ~drop_s;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[g] <= 1'b0;
      else         pend_q[g] <= pend_next_o[g];
    end
  end

  assign pend_q_o = pend_q;
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_agg_pkg::*;
#(
  parameter int unsigned LINES  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [LINES-1:0]  wr_data_i,
  output logic              pri_wr_o,
  output logic [LINES-1:0]  pri_next_o,
  output logic [LINES-1:0]  pri_q_o,
  output logic [LINES-1:0]  casc_q_o
);
  localparam logic [LINES-1:0]  MASK_RST = {LINES{1'b1}};
  localparam logic [ADDR_W-1:0] A_PRI    = ADDR_W'(SEL_PRIMARY);
  localparam logic [ADDR_W-1:0] A_CASC   = ADDR_W'(SEL_CASCADE);

  logic             casc_wr_s;
  logic [LINES-1:0] pri_q;
  logic [LINES-1:0] casc_q;

  assign pri_wr_o   = wr_en_i && (wr_addr_i == A_PRI);
  assign casc_wr_s  = wr_en_i && (wr_addr_i == A_CASC);
  assign pri_next_o = pri_wr_o ? wr_data_i : pri_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_q  <= MASK_RST;
      casc_q <= MASK_RST;
    end else begin
      pri_q <= pri_next_o;
      if (casc_wr_s) casc_q <= wr_data_i;
    end
  end

  assign pri_q_o  = pri_q;
  assign casc_q_o = casc_q;
endmodule

// File: rtl/irq_flag_ctl.sv
module irq_flag_ctl #(
  parameter int unsigned LINES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_valid_i,
  input  logic             clr_valid_i,
  input  logic             pri_wr_i,
  input  logic [LINES-1:0] pend_next_i,
  input  logic [LINES-1:0] mask_next_i,
  output logic             flag_o
);
  logic flag_q;
  logic live_s;
  logic raise_s;
  logic drop_s;

  assign live_s  = |(pend_next_i & mask_next_i);
  assign raise_s = !flag_q && (set_valid_i || pri_wr_i) && live_s;
  assign drop_s  = flag_q && clr_valid_i && !live_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (raise_s) flag_q <= 1'b1;
    else if (drop_s)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned LINES  = LINES_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_valid_i,
  input  logic [LINES-1:0]  set_vec_i,
  input  logic              clr_valid_i,
  input  logic [LINES-1:0]  clr_vec_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [LINES-1:0]  wr_data_i,
  output logic              irq_o,
  output logic [LINES-1:0]  cascade_mask_o
);
  logic [LINES-1:0] pend_next;
  logic [LINES-1:0] pend_q;
  logic [LINES-1:0] mask_next;
  logic [LINES-1:0] mask_q;
  logic             pri_wr;

  irq_pending_reg #(.LINES(LINES)) i_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_valid_i (set_valid_i),
    .set_vec_i   (set_vec_i),
    .clr_valid_i (clr_valid_i),
    .clr_vec_i   (clr_vec_i),
    .pend_next_o (pend_next),
    .pend_q_o    (pend_q)
  );

  irq_mask_bank #(.LINES(LINES), .ADDR_W(ADDR_W)) i_mask (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .pri_wr_o   (pri_wr),
    .pri_next_o (mask_next),
    .pri_q_o    (mask_q),
    .casc_q_o   (cascade_mask_o)
  );

  irq_flag_ctl #(.LINES(LINES)) i_flag (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_valid_i (set_valid_i),
    .clr_valid_i (clr_valid_i),
    .pri_wr_i    (pri_wr),
    .pend_next_i (pend_next),
    .mask_next_i (mask_next),
    .flag_o      (irq_o)
  );
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int unsigned LINES  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              set_valid_i,
  input logic              clr_valid_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [LINES-1:0]  wr_data_i,
  input logic              irq_o,
  input logic [LINES-1:0]  cascade_mask_o,
  input logic [LINES-1:0]  pend_q,
  input logic [LINES-1:0]  mask_q
);
  logic pri_w, casc_w;
  assign pri_w  = wr_en_i && (wr_addr_i == ADDR_W'(1));
  assign casc_w = wr_en_i && (wr_addr_i == ADDR_W'(2));

  assert_reset_low_R1: assert property (@(posedge clk_i)
    !rst_ni |=> !irq_o);

  assert_rise_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(set_valid_i || pri_w));

  assert_fall_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> ($past(clr_valid_i) && ((pend_q & mask_q) == '0)));

  assert_mask_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && pri_w && !clr_valid_i) |=> irq_o);

  assert_cascade_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (casc_w && !set_valid_i && !clr_valid_i) |=> $stable(irq_o));

  assert_cascade_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_w |=> (cascade_mask_o == $past(wr_data_i)));
endmodule

bind irq_agg irq_agg_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .set_valid_i    (set_valid_i),
  .clr_valid_i    (clr_valid_i),
  .wr_en_i        (wr_en_i),
  .wr_addr_i      (wr_addr_i),
  .wr_data_i      (wr_data_i),
  .irq_o          (irq_o),
  .cascade_mask_o (cascade_mask_o),
  .pend_q         (pend_q),
  .mask_q         (mask_q)
);

// File: tb/test_irq_agg.sv
`timescale 1ns/1ps
module test_irq_agg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       set_valid_i = 1'b0;
  logic [7:0] set_vec_i = '0;
  logic       clr_valid_i = 1'b0;
  logic [7:0] clr_vec_i = '0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       irq_o;
  logic [7:0] cascade_mask_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_pend, m_mask, m_casc;
  logic       m_flag;

  always #2 clk_i = ~clk_i;

  irq_agg i_irq_agg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_valid_i(set_valid_i), .set_vec_i(set_vec_i),
    .clr_valid_i(clr_valid_i), .clr_vec_i(clr_vec_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .irq_o(irq_o), .cascade_mask_o(cascade_mask_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    m_pend = '0; m_mask = 8'hFF; m_casc = 8'hFF; m_flag = 1'b0;
  endtask

  // one cycle of stimulus, reference update, check after the edge
  task automatic step(input string tag, input bit sv, input logic [7:0] s,
                      input bit cv, input logic [7:0] c,
                      input bit we, input logic [1:0] a, input logic [7:0] d);
    logic [7:0] pn, mn;
    bit trig;
    @(negedge clk_i);
    set_valid_i = sv; set_vec_i = s; clr_valid_i = cv; clr_vec_i = c;
    wr_en_i = we; wr_addr_i = a; wr_data_i = d;
    pn = sv ? (m_pend | s) : m_pend;
    if (cv) pn = pn & ~c;
    mn = (we && a == 2'd1) ? d : m_mask;
    trig = sv || (we && a == 2'd1);
    if (!m_flag && trig && (pn & mn) != 0) m_flag = 1'b1;
    else if (m_flag && cv && (pn & mn) == 0) m_flag = 1'b0;
    if (we && a == 2'd2) m_casc = d;
    m_pend = pn; m_mask = mn;
    @(posedge clk_i);
    #1;
    set_valid_i = 0; clr_valid_i = 0; wr_en_i = 0;
    check(tag, {7'd0, irq_o}, {7'd0, m_flag});
    check(tag, cascade_mask_o, m_casc);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lfsr;
    do_reset();
    #1;
    // R1: reset state
    check("R1", {7'd0, irq_o}, 8'd0);
    check("R1", cascade_mask_o, 8'hFF);
    step("R1", 1, 8'h80, 0, 0, 0, 0, 0);            // all-ones mask passes bit 7
    // R10: no change before the edge, then held
    step("R10", 0, 0, 0, 0, 0, 0, 0);
    // R2/R3: accumulation and partial clear
    step("R2", 1, 8'h01, 0, 0, 0, 0, 0);
    step("R3", 0, 0, 1, 8'h80, 0, 0, 0);            // bit 0 still pending
    step("R5", 0, 0, 1, 8'h01, 0, 0, 0);            // now empty -> low
    // R7: zero mask while high keeps the line
    step("R4", 1, 8'h04, 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 1, 2'd1, 8'h00);
    step("R5", 0, 0, 1, 8'h00, 0, 0, 0);            // clear of nothing drops since hidden
    // R6: mask write exposes pending bit
    step("R4", 1, 8'h10, 0, 0, 0, 0, 0);            // hidden, stays low
    step("R6", 0, 0, 0, 0, 1, 2'd1, 8'h10);
    // R11: unused addresses
    step("R11", 0, 0, 0, 0, 1, 2'd0, 8'h00);
    step("R11", 0, 0, 0, 0, 1, 2'd3, 8'h00);
    step("R5", 0, 0, 1, 8'h10, 0, 0, 0);
    step("R11", 1, 8'h10, 0, 0, 0, 0, 0);           // mask still 0x10 -> high
    step("R5", 0, 0, 1, 8'hFF, 0, 0, 0);
    // R8: cascade mask has no effect
    step("R8", 0, 0, 0, 0, 1, 2'd2, 8'h5A);
    step("R8", 1, 8'h01, 0, 0, 1, 2'd2, 8'h00);     // hidden by primary 0x10
    step("R8", 0, 0, 1, 8'hFF, 0, 0, 0);
    // R9: same-cycle set and clear
    step("R9", 1, 8'h10, 1, 8'h10, 0, 0, 0);        // clear wins: stays low
    step("R9", 1, 8'h30, 1, 8'h20, 0, 0, 0);        // bit 4 survives: high
    step("R9", 1, 8'h10, 1, 8'h10, 0, 0, 0);        // result empty: low
    // sweep every primary mask against every single-bit request
    for (int m = 0; m < 256; m++) begin
      step("R6", 0, 0, 1, 8'hFF, 1, 2'd1, m[7:0]);
      for (int b = 0; b < 8; b++) begin
        step("R4", 1, 8'(1 << b), 0, 0, 0, 0, 0);
        step("R5", 0, 0, 1, 8'(1 << b), 0, 0, 0);
      end
      step("R2", 1, 8'hFF, 0, 0, 0, 0, 0);
      step("R7", 0, 0, 0, 0, 1, 2'd1, 8'h00);
      step("R3", 0, 0, 1, m[7:0], 0, 0, 0);
    end
    // pseudo-random mixed traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R9", lfsr[0], lfsr[15:8], lfsr[1], {lfsr[3:0], lfsr[11:8]},
           lfsr[2] & lfsr[5], lfsr[7:6], {lfsr[4], lfsr[14:8]});
    end
    // R1: reset in the middle of activity
    step("R1", 1, 8'hFF, 0, 0, 1, 2'd2, 8'h00);
    do_reset();
    #1;
    check("R1", {7'd0, irq_o}, 8'd0);
    check("R1", cascade_mask_o, 8'hFF);
    step("R1", 1, 8'h02, 0, 0, 0, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule